// File: doc/BRIEF.md
# Three-Port Configurable Pin Bank

This block drives the pads of three 8-bit general-purpose I/O ports. Each port has a data register and a direction register. The CPU reaches all six registers through a small synchronous bus, as plain memory locations. A direction bit of 1 makes its pin an output and a direction bit of 0 makes it an input.

Each pin's driver style is fixed at build time:
- **Push-pull pins** drive both levels.
- **Open-drain pins** only pull low and release to high impedance for a 1.
- **Pins in input mode:** the data bit does not act as an output latch. Instead it selects the pull-up: 0 turns the pull-up on and 1 turns it off. A few pin groups have no pull-up at all.

Three port C pins carry serial-interface outputs. These are ANDed with the programmed data bit, so the serial path only works with the pin set to output and the data bit set to 1.

The data register does not read back the latch. It returns the pad level after a two-flop synchronizer, and it does so whatever the direction is. A read-modify-write of a data register can therefore change the pull-up choice of input pins. The design has no state machine: it is a register file, a synchronizer and a per-pin combinational pad controller.

Top module: `gpio_bank`

## Requirements
- R1: After reset, all direction bits read 0 except port C bit 2, which reads 1. Port C's data bit 2 is 1, so that pin is released: its pad_oe is 0 and its pad_pu is 0. Every other implemented pin is an input with pull-up, except the pins with no pull-up.
- R2: Register addresses are as follows. Bit n of each register controls pin n of its port, which is pad index 8*port+n.

  | Address | Register |
  |---|---|
  | 0 | port A data |
  | 1 | port A direction |
  | 2 | port B data |
  | 3 | port B direction |
  | 4 | port C data |
  | 5 | port C direction |

- R3: An implemented input pin with a pull-up has pad_pu equal to the inverse of its data bit. pad_oe and pad_o are 0.
- R4: Pins with no pull-up never assert pad_pu. These are port A bits 4–7 and port C bits 4–7.
- R5: A push-pull output pin has pad_oe = 1 and pad_o equal to its effective value. Push-pull pins are port A bits 0–3 and port B bits 0–6.
- R6: An open-drain output pin has pad_o = 0 and pad_oe equal to the inverse of its effective value. Open-drain pins are port A bits 4–7 and all of port C.
- R7: The effective value is the data bit ANDed with alt_out on port C bits 0, 1 and 3 (pad indices 16, 17 and 19). On every other pin alt_out has no effect.
- R8: Reading a data register returns pad_in of that port through two flops. A change at pad_in shows on bus_rdata after the second rising clock edge, not after the first. This holds in both directions.
- R9: Reading a direction register returns the last value written to it, masked to the implemented bits.
- R10: Port B bit 7 is unimplemented.
  - It reads 0 in both registers and ignores writes.
  - Its pad outputs are always 0.
  - Addresses 6 and 7 read 0 and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| pad_in | input | 24 | Pad input levels, index 8*port+bit |
| alt_out | input | 24 | Serial-interface output values per pad |
| pad_oe | output | 24 | Pad output enable |
| pad_o | output | 24 | Pad output value |
| pad_pu | output | 24 | Pad pull-up enable |

## Verification
The embedded assertions check several rules on every cycle:
- a pull-up is never on while a pin is an output, and never on a pin that has none;
- an open-drain pin never drives high;
- the unimplemented pin stays silent;
- a low serial output always pulls its pad;
- a port A direction write lands one cycle later;
- unmapped addresses read 0.

Other behaviours are shown only by the bench's sweeps: the reset values, the exact two-edge synchronizer latency, the full per-pin truth table across direction and data patterns, and the register readback.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    // Register kind selected by the lowest address bit
    typedef enum logic {
        SEL_DATA = 1'b0,
        SEL_DIR  = 1'b1
    } reg_sel_e;

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int NPORT = 3,
    parameter int PW    = 8,
    parameter logic [NPORT*PW-1:0] IMPL_MASK = 24'hFF7FFF,
    parameter logic [NPORT*PW-1:0] RST_DIR   = 24'h040000,
    parameter logic [NPORT*PW-1:0] RST_DATA  = 24'h040000,
    localparam int NPIN   = NPORT * PW,
    localparam int PIDX_W = (NPORT > 1) ? $clog2(NPORT) : 1,
    localparam int AW     = PIDX_W + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_we,
    input  logic [PW-1:0]   bus_wdata,
    output logic [PW-1:0]   bus_rdata,
    input  logic [NPIN-1:0] pin_lvl,
    output logic [NPIN-1:0] dir_q,
    output logic [NPIN-1:0] data_q
);

    logic [PIDX_W-1:0] port_idx;
    reg_sel_e          sel;

    assign port_idx = bus_addr[AW-1:1];
    assign sel      = reg_sel_e'(bus_addr[0]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= RST_DIR & IMPL_MASK;
            data_q <= RST_DATA & IMPL_MASK;
        end else if (bus_we) begin
            for (int p = 0; p < NPORT; p++) begin
                if (port_idx == PIDX_W'(p)) begin
                    if (sel == SEL_DIR)
                        dir_q[p*PW +: PW]  <= bus_wdata & IMPL_MASK[p*PW +: PW];
                    else
                        data_q[p*PW +: PW] <= bus_wdata & IMPL_MASK[p*PW +: PW];
                end
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int p = 0; p < NPORT; p++) begin
            if (port_idx == PIDX_W'(p)) begin
                if (sel == SEL_DIR)
                    bus_rdata = dir_q[p*PW +: PW];
                else
                    bus_rdata = pin_lvl[p*PW +: PW] & IMPL_MASK[p*PW +: PW];
            end
        end
    end

    // R9
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == AW'(1)) |=>
            (dir_q[PW-1:0] == ($past(bus_wdata) & IMPL_MASK[PW-1:0])));

    // R10
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(bus_addr) >= 2*NPORT) |-> (bus_rdata == '0));

endmodule

// File: rtl/gpio_bank_pad_ctl.sv
module gpio_bank_pad_ctl #(
    parameter bit PRESENT    = 1'b1,
    parameter bit OPEN_DRAIN = 1'b0,
    parameter bit HAS_PU     = 1'b1,
    parameter bit HAS_ALT    = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dir,
    input  logic data,
    input  logic alt,
    output logic pad_oe,
    output logic pad_o,
    output logic pad_pu
);

    logic eff;

    // Serial output wired-AND with the programmed bit on alternate pins
    assign eff = data & (alt | ~HAS_ALT);

    always_comb begin
        pad_oe = 1'b0;
        pad_o  = 1'b0;
        pad_pu = 1'b0;
        if (PRESENT) begin
            if (dir) begin
                if (OPEN_DRAIN) begin
                    pad_oe = ~eff;
                end else begin
                    pad_oe = 1'b1;
                    pad_o  = eff;
                end
            end else begin
                pad_pu = HAS_PU & ~data;
            end
        end
    end

    // R3
    pu_input_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pad_pu |-> !dir);

    generate
        if (OPEN_DRAIN) begin : g_od
            // R6
            od_never_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !pad_o);
        end
        if (!HAS_PU) begin : g_nopu
            // R4
            no_pullup_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !pad_pu);
        end
    endgenerate

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
    parameter int NPORT = 3,
    parameter int PW    = 8,
    parameter logic [NPORT*PW-1:0] IMPL_MASK = 24'hFF7FFF,
    parameter logic [NPORT*PW-1:0] OD_MASK   = 24'hFF00F0,
    parameter logic [NPORT*PW-1:0] NOPU_MASK = 24'hF000F0,
    parameter logic [NPORT*PW-1:0] ALT_MASK  = 24'h0B0000,
    parameter logic [NPORT*PW-1:0] RST_DIR   = 24'h040000,
    parameter logic [NPORT*PW-1:0] RST_DATA  = 24'h040000,
    localparam int NPIN   = NPORT * PW,
    localparam int PIDX_W = (NPORT > 1) ? $clog2(NPORT) : 1,
    localparam int AW     = PIDX_W + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_we,
    input  logic [PW-1:0]   bus_wdata,
    output logic [PW-1:0]   bus_rdata,
    input  logic [NPIN-1:0] pad_in,
    input  logic [NPIN-1:0] alt_out,
    output logic [NPIN-1:0] pad_oe,
    output logic [NPIN-1:0] pad_o,
    output logic [NPIN-1:0] pad_pu
);

    logic [NPIN-1:0] pin_lvl;
    logic [NPIN-1:0] dir_q;
    logic [NPIN-1:0] data_q;

    gpio_bank_sync #(.W(NPIN)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_lvl)
    );

    gpio_bank_regs #(
        .NPORT     (NPORT),
        .PW        (PW),
        .IMPL_MASK (IMPL_MASK),
        .RST_DIR   (RST_DIR),
        .RST_DATA  (RST_DATA)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_lvl   (pin_lvl),
        .dir_q     (dir_q),
        .data_q    (data_q)
    );

    generate
        for (genvar i = 0; i < NPIN; i++) begin : g_pin
            gpio_bank_pad_ctl #(
                .PRESENT    (IMPL_MASK[i]),
                .OPEN_DRAIN (OD_MASK[i]),
                .HAS_PU     (!NOPU_MASK[i]),
                .HAS_ALT    (ALT_MASK[i])
            ) u_pad (
                .clk    (clk),
                .rst_n  (rst_n),
                .dir    (dir_q[i]),
                .data   (data_q[i]),
                .alt    (alt_out[i]),
                .pad_oe (pad_oe[i]),
                .pad_o  (pad_o[i]),
                .pad_pu (pad_pu[i])
            );
        end
    endgenerate

    // R10
    unimpl_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((pad_oe | pad_o | pad_pu) & ~IMPL_MASK) == '0));

    // R7
    alt_low_pulls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((dir_q & ALT_MASK & IMPL_MASK & ~alt_out) & ~pad_oe) == '0));

endmodule

// File: tb/gpio_bank_test.sv
module gpio_bank_test;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [23:0] pad_in = '0;
    logic [23:0] alt_out = '0;
    logic [23:0] pad_oe;
    logic [23:0] pad_o;
    logic [23:0] pad_pu;

    int vectors = 0;
    int fails   = 0;

    always #(CLK_P/2) clk = ~clk;

    gpio_bank uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .alt_out   (alt_out),
        .pad_oe    (pad_oe),
        .pad_o     (pad_o),
        .pad_pu    (pad_pu)
    );

    function automatic bit present(int p, int b);
        return !(p == 1 && b == 7);
    endfunction
    function automatic bit is_od(int p, int b);
        return (p == 0 && b >= 4) || (p == 2);
    endfunction
    function automatic bit has_pu(int p, int b);
        return !((p == 0 || p == 2) && b >= 4);
    endfunction
    function automatic bit has_alt(int p, int b);
        return p == 2 && (b == 0 || b == 1 || b == 3);
    endfunction
    function automatic logic [7:0] impl_of(int p);
        return (p == 1) ? 8'h7F : 8'hFF;
    endfunction

    task automatic model(input int p, input logic [7:0] dir, input logic [7:0] dat,
                         input logic [7:0] alt, output logic [7:0] oe,
                         output logic [7:0] o, output logic [7:0] pu);
        oe = '0; o = '0; pu = '0;
        for (int b = 0; b < 8; b++) begin
            logic e;
            e = dat[b] & (has_alt(p, b) ? alt[b] : 1'b1);
            if (present(p, b)) begin
                if (dir[b]) begin
                    if (is_od(p, b)) oe[b] = !e;
                    else begin oe[b] = 1'b1; o[b] = e; end
                end else begin
                    pu[b] = has_pu(p, b) && !dat[b];
                end
            end
        end
    endtask

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pads_chk(input string req, input int p, input logic [7:0] dir,
                            input logic [7:0] dat, input logic [7:0] alt);
        logic [7:0] eoe, eo, epu;
        model(p, dir, dat, alt, eoe, eo, epu);
        chk({req, " oe"}, pad_oe[p*8 +: 8], eoe);
        chk({req, " o"},  pad_o[p*8 +: 8],  eo);
        chk({req, " pu"}, pad_pu[p*8 +: 8], epu);
    endtask

    localparam logic [7:0] DPAT [6] = '{8'h00, 8'hFF, 8'h0F, 8'hF0, 8'hA5, 8'h5A};

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        #(CLK_P * 150000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd1, r); chk("R1 DDRA", r, 8'h00);
        rd(3'd3, r); chk("R1 DDRB", r, 8'h00);
        rd(3'd5, r); chk("R1 DDRC", r, 8'h04);
        chk("R1 oe",  pad_oe[7:0] | pad_oe[15:8] | pad_oe[23:16], 8'h00);
        chk("R1 o",   pad_o[7:0] | pad_o[15:8] | pad_o[23:16], 8'h00);
        chk("R1 puA", pad_pu[7:0],   8'h0F);
        chk("R1 puB", pad_pu[15:8],  8'h7F);
        chk("R1 puC", pad_pu[23:16], 8'h0B);

        // R2 R3 R4 R5 R6 R9 R10 sweep; alt low on A/B checks R7 ignore
        for (int p = 0; p < 3; p++) begin
            alt_out = (p == 2) ? 24'hFFFFFF : 24'h000000;
            for (int di = 0; di < 6; di++) begin
                wr(3'(2*p+1), DPAT[di]);
                rd(3'(2*p+1), r);
                chk("R9 dir readback", r, DPAT[di] & impl_of(p));
                for (int d = 0; d < 256; d++) begin
                    wr(3'(2*p), 8'(d));
                    pads_chk("R2 R3 R4 R5 R6 R10 pads", p, DPAT[di] & impl_of(p),
                             8'(d) & impl_of(p), alt_out[p*8 +: 8]);
                end
            end
        end

        // R7 wired-AND on port C serial pins
        wr(3'd5, 8'hFF);
        for (int d = 0; d < 256; d++) begin
            wr(3'd4, 8'(d));
            for (int a = 0; a < 8; a++) begin
                logic [7:0] al;
                al = {4'hF, a[2], 1'b1, a[1], a[0]};
                alt_out[23:16] = al;
                #1;
                pads_chk("R7 alt", 2, 8'hFF, 8'(d), al);
            end
        end

        // R8 synchronizer latency, both directions
        for (int p = 0; p < 3; p++) begin
            for (int v = 0; v < 256; v++) begin
                logic [7:0] prev;
                if (v % 64 == 0) wr(3'(2*p+1), (v % 128 == 0) ? 8'h00 : 8'hFF);
                @(negedge clk);
                rd(3'(2*p), prev);
                pad_in[p*8 +: 8] = 8'(v);
                @(negedge clk);
                rd(3'(2*p), r);
                chk("R8 one edge", r, prev);
                @(negedge clk);
                rd(3'(2*p), r);
                chk("R8 two edges", r, 8'(v) & impl_of(p));
            end
        end

        // R10 unmapped addresses
        wr(3'd1, 8'h3C); wr(3'd3, 8'h21); wr(3'd5, 8'h90);
        wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
        rd(3'd6, r); chk("R10 addr6", r, 8'h00);
        rd(3'd7, r); chk("R10 addr7", r, 8'h00);
        rd(3'd1, r); chk("R10 DDRA kept", r, 8'h3C);
        rd(3'd3, r); chk("R10 DDRB kept", r, 8'h21);
        rd(3'd5, r); chk("R10 DDRC kept", r, 8'h90);

        summary();
        $finish;
    end

endmodule